// File: doc/BRIEF.md
# Serial Receive Lane Bring-Up Sequencer

This block is a hardware state machine that takes one serial receive lane from power-down to a linked state without software help. A single start pulse launches a fixed sequence. The sequence first wakes the lane and runs calibration. It then enables the data path and arranges the ready and clock-recovery reset controls so that valid data is already present when clock recovery begins to lock. Finally it releases the clock-recovery reset and polls link status until the link comes up or the poll budget runs out.

Each minimum spacing is a parameter in nanoseconds. It is turned into whole clock cycles from a clock-frequency parameter, always rounding up, so no spacing is ever shorter than asked. One countdown timer is shared by all spacings, by the calibration timeout and by the poll interval. The outcome is reported on two sticky flags, done and error, which hold until the next start.

Top module: `rx_lane_bringup`

## Requirements
- R1: While reset is high and after it, the controls take safe values: lane_pwrdn=1, lane_sleep=1, and cal_enable, rx_data_en, cdr_reset, pcs_ready, done and err are all 0.
- R2: A start pulse seen while the machine is idle, done or failed clears done and err. On the next edge it drives lane_pwrdn=0, keeps lane_sleep=1 and drives every other control to 0. A start pulse during a running sequence has no effect on any output.
- R3: A spacing of T ns lasts ceil(T*CLK_HZ/1e9) cycles, with a minimum of 1. lane_sleep falls one PWRUP_NS spacing after lane_pwrdn falls. cal_enable rises one WAKE_NS spacing after that.
- R4: While calibrating, cal_done is sampled on each edge for one CAL_TIMEOUT_NS spacing. If cal_done is high on the final sampled edge, calibration succeeds. If it is never seen high, err rises and every control then stays frozen until the next start.
- R5: One CAL_SETTLE_NS spacing after cal_done is seen, rx_data_en rises and pcs_ready is 0 on the same edge.
- R6: One RDY_LOW_NS spacing later, cdr_reset rises while pcs_ready is low. One CDR_LEAD_NS spacing after that, pcs_ready rises while cdr_reset is still high.
- R7: cdr_reset falls one CDR_HOLD_NS spacing after pcs_ready rises.
- R8: After cdr_reset falls, link_up is sampled once per POLL_NS spacing, the first sample one spacing after the release. A high sample sets done.
- R9: If POLL_LIMIT samples are all low, err is set on the last one, POLL_LIMIT spacings after the release. A high value on that last sample sets done instead.
- R10: done and err are never high together, and each holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the sequence when the machine is not running |
| cal_done | input | 1 | Calibration finished, from the lane |
| link_up | input | 1 | Link status, from the coding layer |
| lane_pwrdn | output | 1 | Auxiliary receive power-down |
| lane_sleep | output | 1 | Receive sleep |
| cal_enable | output | 1 | Calibration enable |
| rx_data_en | output | 1 | Receive data enable |
| cdr_reset | output | 1 | Clock-recovery reset |
| pcs_ready | output | 1 | Ready indication to the receiver |
| done | output | 1 | Sticky: link seen up |
| err | output | 1 | Sticky: calibration or link timeout |

## Verification
Two cases can fall on the same edge. In the first, cal_done arrives on the very edge where the calibration timeout expires. In the second, link_up turns high on the last permitted poll sample, where a low value would instead end in a timeout. The bench counts negedges from the rising cal_enable, and separately from the release of cdr_reset, to place the input exactly one cycle ahead of the deciding edge. It then requires success (no err, and later done) while a per-cycle reference model tracks every output. A start pulse dropped in the middle of the clock-recovery hold exercises the ignore rule against that same model.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PWR, ST_WAKE, ST_CAL, ST_CALPOST,
      ST_RDYLOW, ST_CDRON, ST_HOLD, ST_POLL, ST_DONE, ST_FAIL
   } rxb_state_e;

   // Round a nanosecond spacing up to whole cycles, never below one.
   function automatic longint unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
      longint unsigned c;
      c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic longint unsigned lmax(longint unsigned a, longint unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rxb_timer.sv
module rxb_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/rxb_sample_ctr.sv
module rxb_sample_ctr #(
   parameter int unsigned LIMIT = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt <= '0;
      else if (inc)    cnt <= cnt + 1'b1;
   end

   assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/rx_lane_bringup.sv
module rx_lane_bringup
   import rxb_pkg::*;
#(
   parameter longint unsigned CLK_HZ         = 100_000_000,
   parameter longint unsigned PWRUP_NS       = 50,
   parameter longint unsigned WAKE_NS        = 500,
   parameter longint unsigned CAL_SETTLE_NS  = 50,
   parameter longint unsigned RDY_LOW_NS     = 50,
   parameter longint unsigned CDR_LEAD_NS    = 50,
   parameter longint unsigned CDR_HOLD_NS    = 30_000_000,
   parameter longint unsigned POLL_NS        = 500_000,
   parameter longint unsigned CAL_TIMEOUT_NS = 1_000_000,
   parameter int unsigned     POLL_LIMIT     = 2000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic cal_done,
   input  logic link_up,
   output logic lane_pwrdn,
   output logic lane_sleep,
   output logic cal_enable,
   output logic rx_data_en,
   output logic cdr_reset,
   output logic pcs_ready,
   output logic done,
   output logic err
);
   localparam longint unsigned C_PWR  = ns2cyc(PWRUP_NS, CLK_HZ);
   localparam longint unsigned C_WAKE = ns2cyc(WAKE_NS, CLK_HZ);
   localparam longint unsigned C_CALP = ns2cyc(CAL_SETTLE_NS, CLK_HZ);
   localparam longint unsigned C_RDY  = ns2cyc(RDY_LOW_NS, CLK_HZ);
   localparam longint unsigned C_CDR  = ns2cyc(CDR_LEAD_NS, CLK_HZ);
   localparam longint unsigned C_HOLD = ns2cyc(CDR_HOLD_NS, CLK_HZ);
   localparam longint unsigned C_POLL = ns2cyc(POLL_NS, CLK_HZ);
   localparam longint unsigned C_CALT = ns2cyc(CAL_TIMEOUT_NS, CLK_HZ);
   localparam longint unsigned C_MAX  =
      lmax(lmax(lmax(C_PWR, C_WAKE), lmax(C_CALP, C_RDY)),
           lmax(lmax(C_CDR, C_HOLD), lmax(C_POLL, C_CALT)));
   localparam int TW = (C_MAX < 2) ? 1 : $clog2(C_MAX);

   localparam logic [TW-1:0] L_PWR  = TW'(C_PWR  - 1);
   localparam logic [TW-1:0] L_WAKE = TW'(C_WAKE - 1);
   localparam logic [TW-1:0] L_CALP = TW'(C_CALP - 1);
   localparam logic [TW-1:0] L_RDY  = TW'(C_RDY  - 1);
   localparam logic [TW-1:0] L_CDR  = TW'(C_CDR  - 1);
   localparam logic [TW-1:0] L_HOLD = TW'(C_HOLD - 1);
   localparam logic [TW-1:0] L_POLL = TW'(C_POLL - 1);
   localparam logic [TW-1:0] L_CALT = TW'(C_CALT - 1);

   if (CLK_HZ == 0) begin : g_bad_clk
      $error("rx_lane_bringup: CLK_HZ must be nonzero");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("rx_lane_bringup: POLL_LIMIT must be at least 1");
   end
   if (TW > 40) begin : g_bad_width
      $error("rx_lane_bringup: spacing too long for timer");
   end

   rxb_state_e st, nxt;
   logic [7:0] ctl, ctl_nxt;   // {pwrdn, sleep, cal, data, cdr, rdy, done, err}
   logic          tm_load, tm_exp;
   logic [TW-1:0] tm_val;
   logic          sc_clr, sc_inc, sc_last;

   rxb_timer #(.W(TW)) u_timer (
      .clk(clk), .rst(rst), .load(tm_load), .val(tm_val), .expired(tm_exp)
   );

   rxb_sample_ctr #(.LIMIT(POLL_LIMIT)) u_samples (
      .clk(clk), .rst(rst), .clr(sc_clr), .inc(sc_inc), .last(sc_last)
   );

   always_comb begin
      nxt     = st;
      ctl_nxt = ctl;
      tm_load = 1'b0;
      tm_val  = '0;
      sc_clr  = 1'b0;
      sc_inc  = 1'b0;
      unique case (st)
         ST_IDLE, ST_DONE, ST_FAIL: begin
            if (start) begin
               ctl_nxt = 8'b0100_0000;
               tm_load = 1'b1;
               tm_val  = L_PWR;
               nxt     = ST_PWR;
            end
         end
         ST_PWR: if (tm_exp) begin
            ctl_nxt[6] = 1'b0;
            tm_load = 1'b1; tm_val = L_WAKE; nxt = ST_WAKE;
         end
         ST_WAKE: if (tm_exp) begin
            ctl_nxt[5] = 1'b1;
            tm_load = 1'b1; tm_val = L_CALT; nxt = ST_CAL;
         end
         ST_CAL: begin
            if (cal_done) begin
               tm_load = 1'b1; tm_val = L_CALP; nxt = ST_CALPOST;
            end else if (tm_exp) begin
               ctl_nxt[0] = 1'b1;
               nxt = ST_FAIL;
            end
         end
         ST_CALPOST: if (tm_exp) begin
            ctl_nxt[4] = 1'b1;
            ctl_nxt[2] = 1'b0;
            tm_load = 1'b1; tm_val = L_RDY; nxt = ST_RDYLOW;
         end
         ST_RDYLOW: if (tm_exp) begin
            ctl_nxt[3] = 1'b1;
            tm_load = 1'b1; tm_val = L_CDR; nxt = ST_CDRON;
         end
         ST_CDRON: if (tm_exp) begin
            ctl_nxt[2] = 1'b1;
            tm_load = 1'b1; tm_val = L_HOLD; nxt = ST_HOLD;
         end
         ST_HOLD: if (tm_exp) begin
            ctl_nxt[3] = 1'b0;
            tm_load = 1'b1; tm_val = L_POLL; sc_clr = 1'b1; nxt = ST_POLL;
         end
         ST_POLL: if (tm_exp) begin
            if (link_up) begin
               ctl_nxt[1] = 1'b1; nxt = ST_DONE;
            end else if (sc_last) begin
               ctl_nxt[0] = 1'b1; nxt = ST_FAIL;
            end else begin
               sc_inc = 1'b1; tm_load = 1'b1; tm_val = L_POLL;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_IDLE;
         ctl <= 8'b1100_0000;
      end else begin
         st  <= nxt;
         ctl <= ctl_nxt;
      end
   end

   assign {lane_pwrdn, lane_sleep, cal_enable, rx_data_en,
           cdr_reset, pcs_ready, done, err} = ctl;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker (
   input logic clk,
   input logic rst,
   input logic start,
   input logic lane_pwrdn,
   input logic lane_sleep,
   input logic cal_enable,
   input logic rx_data_en,
   input logic cdr_reset,
   input logic pcs_ready,
   input logic done,
   input logic err
);
   a_r3_wake_after_pwr: assert property (@(posedge clk) disable iff (rst)
      $fell(lane_sleep) |-> !lane_pwrdn);

   a_r3_cal_after_wake: assert property (@(posedge clk) disable iff (rst)
      $rose(cal_enable) |-> !lane_sleep);

   a_r5_data_with_rdy_low: assert property (@(posedge clk) disable iff (rst)
      $rose(rx_data_en) |-> (cal_enable && !pcs_ready));

   a_r6_rdy_low_at_cdr: assert property (@(posedge clk) disable iff (rst)
      $rose(cdr_reset) |-> (!pcs_ready && rx_data_en));

   a_r6_rdy_under_cdr: assert property (@(posedge clk) disable iff (rst)
      $rose(pcs_ready) |-> cdr_reset);

   a_r7_release_after_rdy: assert property (@(posedge clk) disable iff (rst)
      $fell(cdr_reset) |-> pcs_ready);

   a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(done && err));

   a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

   a_r4_fail_frozen: assert property (@(posedge clk) disable iff (rst)
      (err && !start) |=> (err && $stable({lane_pwrdn, lane_sleep, cal_enable,
                                           rx_data_en, cdr_reset, pcs_ready})));
endmodule

bind rx_lane_bringup rxb_checker u_rxb_checker (
   .clk(clk), .rst(rst), .start(start),
   .lane_pwrdn(lane_pwrdn), .lane_sleep(lane_sleep), .cal_enable(cal_enable),
   .rx_data_en(rx_data_en), .cdr_reset(cdr_reset), .pcs_ready(pcs_ready),
   .done(done), .err(err)
);

// File: tb/tb_rx_lane_bringup.sv
module tb_rx_lane_bringup;
   localparam int CLK_PERIOD = 10;
   localparam longint HZ    = 30_000_000;
   localparam longint NS_PWR = 50, NS_WAKE = 500, NS_CALP = 50, NS_RDY = 50;
   localparam longint NS_CDR = 50, NS_HOLD = 1000, NS_POLL = 400, NS_CALT = 300;
   localparam int     LIMIT = 4;

   function automatic int cyc(longint ns);
      longint c;
      c = (ns * HZ + 999_999_999) / 1_000_000_000;
      return (c < 1) ? 1 : int'(c);
   endfunction

   logic clk = 0, rst = 1, start = 0, cal_done = 0, link_up = 0;
   logic lane_pwrdn, lane_sleep, cal_enable, rx_data_en, cdr_reset, pcs_ready, done, err;
   int checks = 0, failures = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_lane_bringup #(
      .CLK_HZ(HZ), .PWRUP_NS(NS_PWR), .WAKE_NS(NS_WAKE), .CAL_SETTLE_NS(NS_CALP),
      .RDY_LOW_NS(NS_RDY), .CDR_LEAD_NS(NS_CDR), .CDR_HOLD_NS(NS_HOLD),
      .POLL_NS(NS_POLL), .CAL_TIMEOUT_NS(NS_CALT), .POLL_LIMIT(LIMIT)
   ) dut (
      .clk(clk), .rst(rst), .start(start), .cal_done(cal_done), .link_up(link_up),
      .lane_pwrdn(lane_pwrdn), .lane_sleep(lane_sleep), .cal_enable(cal_enable),
      .rx_data_en(rx_data_en), .cdr_reset(cdr_reset), .pcs_ready(pcs_ready),
      .done(done), .err(err)
   );

   wire [7:0] outs = {lane_pwrdn, lane_sleep, cal_enable, rx_data_en,
                      cdr_reset, pcs_ready, done, err};

   task automatic chk(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // Behavioural reference model, updated on each rising edge.
   bit [7:0] m = 8'b1100_0000;
   int ph = 0, left = 0, n = 0;
   string m_req = "R1";

   always @(posedge clk) begin
      if (rst) begin
         m = 8'b1100_0000; ph = 0; m_req = "R1";
      end else if (ph == 0) begin
         if (start) begin
            m = 8'b0100_0000; ph = 1; left = cyc(NS_PWR); m_req = "R2";
         end
      end else begin
         case (ph)
            1: begin left--; if (left == 0) begin m[6] = 0; ph = 2; left = cyc(NS_WAKE); m_req = "R3"; end end
            2: begin left--; if (left == 0) begin m[5] = 1; ph = 3; left = cyc(NS_CALT); m_req = "R3"; end end
            3: begin
               if (cal_done) begin ph = 4; left = cyc(NS_CALP); m_req = "R4"; end
               else begin left--; if (left == 0) begin m[0] = 1; ph = 0; m_req = "R4"; end end
            end
            4: begin left--; if (left == 0) begin m[4] = 1; m[2] = 0; ph = 5; left = cyc(NS_RDY); m_req = "R5"; end end
            5: begin left--; if (left == 0) begin m[3] = 1; ph = 6; left = cyc(NS_CDR); m_req = "R6"; end end
            6: begin left--; if (left == 0) begin m[2] = 1; ph = 7; left = cyc(NS_HOLD); m_req = "R6"; end end
            7: begin left--; if (left == 0) begin m[3] = 0; ph = 8; n = 0; left = cyc(NS_POLL); m_req = "R7"; end end
            8: begin
               left--;
               if (left == 0) begin
                  m_req = "R8";
                  if (link_up) begin m[1] = 1; ph = 0; end
                  else if (n == LIMIT - 1) begin m[0] = 1; ph = 0; m_req = "R9"; end
                  else begin n++; left = cyc(NS_POLL); end
               end
            end
            default: ph = 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (!rst && !finished) chk({m_req, " model compare"}, int'(outs), int'(m));
   end

   task automatic pulse_start();
      start = 1; @(negedge clk); start = 0;
   endtask

   initial begin
      int k;
      repeat (3) @(negedge clk);
      chk("R1 reset values", int'(outs), 8'hC0);
      rst = 0;
      @(negedge clk);
      chk("R1 after reset", int'(outs), 8'hC0);

      // Run A: normal bring-up, link up on first sample.
      @(negedge clk);
      pulse_start();
      chk("R2 pwrdn released", int'(outs), 8'h40);
      k = 0; while (lane_sleep) begin @(negedge clk); k++; end
      chk("R3 pwr spacing", k, cyc(NS_PWR));
      k = 0; while (!cal_enable) begin @(negedge clk); k++; end
      chk("R3 wake spacing", k, cyc(NS_WAKE));
      repeat (3) @(negedge clk);
      cal_done = 1;
      k = 0; while (!rx_data_en) begin @(negedge clk); k++; end
      cal_done = 0;
      chk("R5 settle spacing", k, cyc(NS_CALP) + 1);
      chk("R5 rdy low with data", int'(pcs_ready), 0);
      k = 0; while (!cdr_reset) begin @(negedge clk); k++; end
      chk("R6 cdr spacing", k, cyc(NS_RDY));
      k = 0; while (!pcs_ready) begin @(negedge clk); k++; end
      chk("R6 rdy lead spacing", k, cyc(NS_CDR));
      repeat (4) @(negedge clk);
      pulse_start();
      chk("R2 start ignored mid-hold", int'(outs), 8'h3C);
      k = 5; while (cdr_reset) begin @(negedge clk); k++; end
      chk("R7 hold spacing", k, cyc(NS_HOLD));
      link_up = 1;
      k = 0; while (!done && !err) begin @(negedge clk); k++; end
      chk("R8 first sample", k, cyc(NS_POLL));
      chk("R8 done set", int'(outs), 8'h36);
      link_up = 0;
      repeat (5) @(negedge clk);
      chk("R10 done holds", int'({done, err}), 2);

      // Run B: calibration never finishes.
      pulse_start();
      chk("R10 done cleared by start", int'({done, err}), 0);
      while (!err) @(negedge clk);
      chk("R4 timeout error", int'(outs), 8'h21);
      repeat (6) @(negedge clk);
      chk("R4 controls frozen", int'(outs), 8'h21);

      // Run C: cal_done on last edge; link up on last sample.
      pulse_start();
      while (!cal_enable) @(negedge clk);
      repeat (cyc(NS_CALT) - 1) @(negedge clk);
      cal_done = 1;
      @(negedge clk);
      cal_done = 0;
      chk("R4 cal on final edge", int'(err), 0);
      while (!pcs_ready) @(negedge clk);
      while (cdr_reset) @(negedge clk);
      repeat (LIMIT * cyc(NS_POLL) - 1) @(negedge clk);
      link_up = 1;
      @(negedge clk);
      chk("R9 link on last sample", int'({done, err}), 2);
      link_up = 0;

      // Run D: link never comes up.
      pulse_start();
      while (!cal_enable) @(negedge clk);
      cal_done = 1; @(negedge clk); cal_done = 0;
      while (!pcs_ready) @(negedge clk);
      while (cdr_reset) @(negedge clk);
      k = 0; while (!err && !done) begin @(negedge clk); k++; end
      chk("R9 poll budget", k, LIMIT * cyc(NS_POLL));
      chk("R9 link timeout", int'(outs), 8'h35);
      repeat (3) @(negedge clk);
      chk("R10 err holds", int'({done, err}), 1);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL R2 watchdog actual=hung expected=complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule